// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a page frame to evict from a table of frames. It does not keep a full least-recently-used order. Each frame has one "used" flag and one "dirty" flag instead, and a circular hand walks the table. A reference event names a frame. It sets that frame's used flag, and it also sets the dirty flag when the access was a write.

A replacement request starts a sweep. The sweep begins at the entry after the hand's resting place and inspects one entry per clock. Any entry found in use is cleared, which gives it a second chance, and the hand moves on. The first entry found unused becomes the victim.

The victim is reported with a one-cycle grant pulse, together with its dirty flag, so that the requester can schedule a writeback before reusing the frame. The hand then rests on the victim. The dirty flag of the victim is cleared at the grant, because the frame is about to hold a new page.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every used and dirty flag is clear, `grant` is low, `victim` and `victim_dirty` are 0, and the hand rests on frame FRAMES-1, so the first sweep begins at frame 0.
- R2: A cycle with `ref_valid` high sets the used flag of frame `ref_frame`; a frame referenced since it was last passed is skipped by the next sweep.
- R3: A sweep reports the first frame, counting forward from the entry after the hand, whose used flag is 0.
- R4: Every frame a sweep passes over because its used flag was 1 has that flag cleared, so a later sweep can choose it.
- R5: One entry is inspected per clock. If `req` is sampled high by an idle selector at edge e and the victim is the k-th entry inspected, `grant` rises after edge e+k. With every flag set, k = FRAMES+1.
- R6: `grant` is high for exactly one cycle per sweep, and `victim` and `victim_dirty` are valid in that cycle. While idle, a sampled `req` starts a new sweep.
- R7: After a grant the hand rests on the victim, so the next sweep begins at the frame after it.
- R8: When a reference names the entry that the sweep inspects in the same cycle, the set wins. That entry is neither cleared nor chosen, and it stays used for the next sweep.
- R9: A reference with `ref_write` high also sets the frame's dirty flag. `victim_dirty` reports the victim's dirty flag, and that flag is cleared at the grant.
- R10: The hand wraps from frame FRAMES-1 to frame 0 for any FRAMES of at least 2, including values that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| ref_write | input | 1 | The reference was a write (sets dirty) |
| req | input | 1 | Request a victim; sampled while idle |
| grant | output | 1 | One-cycle pulse: victim is valid |
| victim | output | IDX_W | Chosen frame index |
| victim_dirty | output | 1 | Chosen frame needs writeback |

## Verification
The bench aims at three corner cases.

- **Full table.** With every used flag set, the sweep must run a whole lap plus one step and return the frame just after the hand. A design that stops after one lap would return the wrong frame or hang, and one that fails to clear passed entries would never finish.
- **Collision and wrap.** A reference lands on the entry being inspected in that exact cycle, and then a later sweep must skip that entry. A design where the clear wins would hand out a frame that is in use. The non-power-of-two table size exposes a hand that fails to wrap at FRAMES-1.
- **Dirty flag across two grants.** A dirty flag that is not cleared at grant would show up as a spurious writeback on the frame's next eviction.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
   typedef enum logic {
      HAND_IDLE  = 1'b0,
      HAND_SWEEP = 1'b1
   } hand_state_e;
endpackage

// File: rtl/clk_idx_step.sv
// Modular increment of a frame index; the variant depends on FRAMES.
module clk_idx_step #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] nxt
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);
   localparam bit IS_POW2 = ((FRAMES & (FRAMES - 1)) == 0);

   generate
      if (IS_POW2) begin : g_natural
         assign nxt = cur + IDX_W'(1);
      end else begin : g_compare
         assign nxt = (cur == LAST) ? '0 : cur + IDX_W'(1);
      end
   endgenerate
endmodule

// File: rtl/clk_flag_bank.sv
// Per-frame used and dirty flags. A set takes priority over a clear.
module clk_flag_bank #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IDX_W-1:0]  set_idx,
   input  logic              set_dirty,
   input  logic              clr_used_en,
   input  logic              clr_dirty_en,
   input  logic [IDX_W-1:0]  probe_idx,
   output logic              probe_used,
   output logic              probe_dirty,
   output logic [FRAMES-1:0] used_vec
);
   logic [FRAMES-1:0] dirty_vec;

   generate
      for (genvar i = 0; i < FRAMES; i++) begin : g_frame
         logic hit_set, hit_probe;
         assign hit_set   = set_en && (set_idx == IDX_W'(i));
         assign hit_probe = (probe_idx == IDX_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               used_vec[i]  <= 1'b0;
               dirty_vec[i] <= 1'b0;
            end else begin
               if (hit_set)
                  used_vec[i] <= 1'b1;
               else if (clr_used_en && hit_probe)
                  used_vec[i] <= 1'b0;

               if (hit_set && set_dirty)
                  dirty_vec[i] <= 1'b1;
               else if (clr_dirty_en && hit_probe)
                  dirty_vec[i] <= 1'b0;
            end
         end
      end
   endgenerate

   // A same-cycle reference makes the probed frame count as used.
   assign probe_used  = used_vec[probe_idx] | (set_en && (set_idx == probe_idx));
   assign probe_dirty = dirty_vec[probe_idx];
endmodule

// File: rtl/clk_sweep_ctrl.sv
// The hand: idle/sweep state, resting pointer, candidate and grant outputs.
module clk_sweep_ctrl
   import clk_repl_pkg::*;
#(
   parameter int FRAMES = 16,
   parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             cand_used,
   input  logic             cand_dirty,
   output logic [IDX_W-1:0] cand,
   output logic             clr_used,
   output logic             take,
   output logic             sweeping,
   output logic             grant,
   output logic [IDX_W-1:0] victim,
   output logic             victim_dirty
);
   localparam logic [IDX_W-1:0] HOME = IDX_W'(FRAMES - 1);

   hand_state_e      state;
   logic [IDX_W-1:0] hand;
   logic [IDX_W-1:0] hand_nxt, cand_nxt;

   clk_idx_step #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_step_hand (.cur(hand), .nxt(hand_nxt));
   clk_idx_step #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_step_cand (.cur(cand), .nxt(cand_nxt));

   assign sweeping = (state == HAND_SWEEP);
   assign take     = sweeping && !cand_used;
   assign clr_used = sweeping &&  cand_used;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= HAND_IDLE;
         hand         <= HOME;
         cand         <= '0;
         grant        <= 1'b0;
         victim       <= '0;
         victim_dirty <= 1'b0;
      end else begin
         grant <= 1'b0;
         unique case (state)
            HAND_IDLE: begin
               if (req) begin
                  state <= HAND_SWEEP;
                  cand  <= hand_nxt;
               end
            end
            HAND_SWEEP: begin
               if (take) begin
                  grant        <= 1'b1;
                  victim       <= cand;
                  victim_dirty <= cand_dirty;
                  hand         <= cand;
                  state        <= HAND_IDLE;
               end else begin
                  cand <= cand_nxt;
               end
            end
            default: state <= HAND_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_valid,
   input  logic [IDX_W-1:0] ref_frame,
   input  logic             ref_write,
   input  logic             req,
   output logic             grant,
   output logic [IDX_W-1:0] victim,
   output logic             victim_dirty
);
   generate
      if (FRAMES < 2) begin : g_bad_frames
         $error("clock_victim_sel: FRAMES must be at least 2");
      end
      if (IDX_W < $clog2(FRAMES)) begin : g_bad_width
         $error("clock_victim_sel: IDX_W too narrow for FRAMES");
      end
   endgenerate

   logic [IDX_W-1:0]  cand;
   logic              cand_used, cand_dirty, clr_used, take, sweeping;
   logic [FRAMES-1:0] used_vec;

   clk_flag_bank #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_en       (ref_valid),
      .set_idx      (ref_frame),
      .set_dirty    (ref_write),
      .clr_used_en  (clr_used),
      .clr_dirty_en (take),
      .probe_idx    (cand),
      .probe_used   (cand_used),
      .probe_dirty  (cand_dirty),
      .used_vec     (used_vec)
   );

   clk_sweep_ctrl #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .cand_used    (cand_used),
      .cand_dirty   (cand_dirty),
      .cand         (cand),
      .clr_used     (clr_used),
      .take         (take),
      .sweeping     (sweeping),
      .grant        (grant),
      .victim       (victim),
      .victim_dirty (victim_dirty)
   );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_valid,
   input logic [IDX_W-1:0]  ref_frame,
   input logic              grant,
   input logic [IDX_W-1:0]  victim,
   input logic              sweeping,
   input logic [FRAMES-1:0] used_vec
);
   int sweep_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)        sweep_cnt <= 0;
      else if (sweeping) sweep_cnt <= sweep_cnt + 1;
      else               sweep_cnt <= 0;
   end

   AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sweeping |-> (sweep_cnt <= FRAMES)) else $error("sweep too long"); // R5
   AST_GRANT_FROM_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> $past(sweeping)) else $error("grant without sweep"); // R5
   AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant) else $error("grant longer than one cycle"); // R6
   AST_REF_SETS_USED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |=> used_vec[$past(ref_frame)]) else $error("reference lost"); // R8
   AST_VICTIM_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !used_vec[victim]) else $error("victim marked used"); // R3
   AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(victim) < FRAMES) else $error("victim out of range"); // R10
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_valid (ref_valid),
   .ref_frame (ref_frame),
   .grant     (grant),
   .victim    (victim),
   .sweeping  (sweeping),
   .used_vec  (used_vec)
);

// File: tb/clock_victim_sel_test.sv
`timescale 1ns/1ps
module clock_victim_sel_test;
   localparam int F = 6;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ref_valid = 1'b0;
   logic [W-1:0] ref_frame = '0;
   logic         ref_write = 1'b0;
   logic         req = 1'b0;
   logic         grant;
   logic [W-1:0] victim;
   logic         victim_dirty;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #4 clk = ~clk;  // 125 MHz

   clock_victim_sel #(.FRAMES(F), .IDX_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
      .ref_write(ref_write), .req(req), .grant(grant), .victim(victim),
      .victim_dirty(victim_dirty)
   );

   // Behavioural reference model
   int m_used[F];
   int m_dirty[F];
   int m_hand, m_cand;
   bit m_sweep;
   bit e_grant;
   int e_victim, e_vd;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_used[i]) begin m_used[i] = 0; m_dirty[i] = 0; end
         m_hand = F - 1; m_cand = 0; m_sweep = 0;
         e_grant = 0; e_victim = 0; e_vd = 0;
      end else begin
         e_grant = 0;
         if (m_sweep) begin
            if (m_used[m_cand] == 0 && !(ref_valid && int'(ref_frame) == m_cand)) begin
               e_grant = 1; e_victim = m_cand; e_vd = m_dirty[m_cand];
               m_dirty[m_cand] = 0; m_hand = m_cand; m_sweep = 0;
            end else begin
               m_used[m_cand] = 0;
               m_cand = (m_cand + 1) % F;
            end
         end else if (req) begin
            m_sweep = 1; m_cand = (m_hand + 1) % F;
         end
         if (ref_valid) begin
            m_used[ref_frame] = 1;
            if (ref_write) m_dirty[ref_frame] = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (grant !== e_grant ||
             (e_grant && (int'(victim) != e_victim || int'(victim_dirty) != e_vd))) begin
            bad++;
            $display("FAIL R6 model: grant=%0b victim=%0d dirty=%0b expected grant=%0b victim=%0d dirty=%0d",
                     grant, victim, victim_dirty, e_grant, e_victim, e_vd);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic touch(input int fr, input bit wr);
      ref_valid = 1'b1; ref_frame = W'(fr); ref_write = wr;
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
   endtask

   // rat: cycle count at which a reference to rfr is driven (-1: none)
   task automatic do_req(input int ev, input int evd, input int elat,
                         input int rat, input int rfr, input string tag);
      int lat = 0;
      req = 1'b1;
      while (1) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         ref_valid = 1'b0;
         if (grant || lat > 40) break;
         if (lat == rat) begin
            ref_valid = 1'b1; ref_frame = W'(rfr); ref_write = 1'b0;
         end
      end
      req = 1'b0;
      ref_valid = 1'b0;
      check(grant == 1'b1, {tag, " grant"}, int'(grant), 1);
      check(int'(victim) == ev, {tag, " victim"}, int'(victim), ev);
      check(int'(victim_dirty) == evd, {tag, " dirty"}, int'(victim_dirty), evd);
      check(lat == elat, {tag, " latency"}, lat, elat);
      @(negedge clk);
      check(grant == 1'b0, "R6 pulse width", int'(grant), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(grant == 1'b0 && victim == '0 && victim_dirty == 1'b0, "R1 reset outputs",
            int'(grant) + int'(victim) + int'(victim_dirty), 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_req(0, 0, 2, -1, 0, "R1 first sweep");
      touch(1, 0);
      touch(2, 1);
      do_req(3, 0, 4, -1, 0, "R3 R2 skip used");
      do_req(4, 0, 2, -1, 0, "R7 next after hand");
      do_req(5, 0, 2, -1, 0, "R7 next after hand");
      do_req(0, 0, 2, -1, 0, "R10 wrap");
      do_req(1, 0, 2, -1, 0, "R4 cleared frame");
      do_req(2, 1, 2, -1, 0, "R9 dirty victim");
      do_req(3, 0, 2, -1, 0, "R7 advance");
      for (int i = 0; i < F; i++) touch(i, 0);
      do_req(4, 0, F + 2, -1, 0, "R5 full lap");
      do_req(0, 0, 3, 1, 5, "R8 collision");
      for (int i = 1; i < 5; i++) touch(i, 0);
      do_req(0, 0, 7, -1, 0, "R8 set kept");
      touch(1, 1);
      do_req(2, 0, 3, -1, 0, "R9 write marks used");
      do_req(3, 0, 2, -1, 0, "R7 step");
      do_req(4, 0, 2, -1, 0, "R7 step");
      do_req(5, 0, 2, -1, 0, "R7 step");
      do_req(0, 0, 2, -1, 0, "R10 wrap again");
      do_req(1, 1, 2, -1, 0, "R9 dirty reported");
      for (int i = 0; i < 5; i++) do_req((2 + i) % F, 0, 2, -1, 0, "R7 lap");
      do_req(1, 0, 2, -1, 0, "R9 dirty cleared");
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule